// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block sits between an external microprocessor bus and the inside of a chip. Over a 16-bit asynchronous bus the host reaches two targets. One is a dual-port RAM addressed by a 12-bit word address. The RAM itself lives outside this block; the block drives its host-side port. The other target is a file of 128 16-bit control registers addressed by the low 7 address bits. Two bus styles are accepted. In the first style, separate active-low read and write strobes are used. In the second, one data strobe of programmable polarity is paired with a read/write direction line. The strobe, direction and select pins pass through a two-flop synchroniser. The block then finds the leading edge of the decoded strobe.

A RAM access pulls `h_busy_n` low until the access is done. For a read, data is driven once busy is released. For a write, busy is released while the host still holds its strobe, and the word is committed after the strobe ends. If the internal side is using the RAM, the host waits with busy held low. A request line tells the internal side to let the host go first. A DMA request flag is set by an internal pulse and is cleared by any host write to a control register.

The controller has six states. IDLE waits for a strobe edge. WAIT holds a RAM access until the internal side is free. RD_RUN counts the RAM read latency, or loads a register read. RD_HOLD drives data until the strobe ends. WR_HOLD keeps the captured write until the strobe ends. WR_COMMIT performs the write for one cycle.

The transitions are:
- IDLE→WAIT on a strobe edge with the RAM selected.
- IDLE→RD_RUN or IDLE→WR_HOLD on a strobe edge with the register file selected.
- WAIT→RD_RUN or WAIT→WR_HOLD once `ram_int_busy` is low.
- RD_RUN→RD_HOLD when the latency count ends, or at once for a register.
- RD_HOLD→IDLE and WR_HOLD→WR_COMMIT when the strobe goes inactive.
- WR_COMMIT→IDLE always.

Top module: `hbus_bridge`

## Requirements
- R1: After reset, `h_busy_n`=1, `h_doe`=0, `dma_req`=0 and `ram_en`=0.
- R2: With `cfg_moto`=0, `h_rd_n` low with both `h_ram_cs_n` bits low reads the RAM word at `h_addr`. That word appears on `h_dout` with `h_doe`=1 after busy is released.
- R3: For a RAM read with the internal side idle, `h_busy_n` first reads low 3 clock edges after the strobe's leading edge. It stays low for 1+L cycles, where L=2 with `cfg_ram_x2`=0 and L=1 with `cfg_ram_x2`=1. `h_busy_n` and `h_doe` are never both active.
- R4: With `cfg_moto`=1, `h_rd_n` is the strobe. It is active low when `cfg_strobe_hi`=0 and active high when `cfg_strobe_hi`=1. `h_wr_n` low selects a write and high selects a read.
- R5: On a RAM write, busy returns high while the host strobe is still active. The data held during the strobe is committed with a single-cycle `ram_we` pulse after the strobe ends.
- R6: A write with `h_ub_n`=1 updates only bits 7:0 (`ram_be`=2'b01). A write with `h_ub_n`=0 updates both bytes (`ram_be`=2'b11). Register writes follow the same rule.
- R7: While `ram_int_busy`=1, a pending host RAM access keeps `h_busy_n` low, asserts `ram_host_req` and does not raise `ram_en`. It completes once `ram_int_busy` falls.
- R8: The register file is selected only when `h_reg_cs_n`=0 and `h_reg_cs`=1. It uses `h_addr[6:0]`, so upper address bits alias. Its accesses never pull busy low.
- R9: A `dma_set` pulse raises `dma_req` on the next cycle. A host register write clears it.
- R10: After a read strobe ends, `h_doe` reads low 3 clock edges later.
- R11: A strobe with no target selected has no effect. Busy stays high, `h_doe` stays 0, and no RAM cycle occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_moto | input | 1 | 1: single strobe plus direction line; 0: separate read/write strobes |
| cfg_strobe_hi | input | 1 | Single-strobe style: strobe active high when 1 |
| cfg_ram_x2 | input | 1 | RAM access clock at twice the system clock when 1 |
| h_rd_n | input | 1 | Read strobe, or the data strobe in single-strobe style |
| h_wr_n | input | 1 | Write strobe, or the direction line (low = write) |
| h_ram_cs_n | input | 2 | RAM selects, both low to select |
| h_reg_cs_n | input | 1 | Register select, active low |
| h_reg_cs | input | 1 | Register select, active high |
| h_ub_n | input | 1 | Upper byte lane enable, active low |
| h_addr | input | 12 | Host word address |
| h_din | input | 16 | Host write data |
| h_dout | output | 16 | Read data to the pad |
| h_doe | output | 1 | Pad output enable for `h_dout` |
| h_busy_n | output | 1 | Wait signal to host, low while a RAM access is pending |
| ram_int_busy | input | 1 | Internal side currently using the RAM |
| ram_host_req | output | 1 | Host holds or awaits the RAM |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write pulse |
| ram_be | output | 2 | RAM byte enables, bit 1 = upper byte |
| ram_addr | output | 12 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, valid for the held address |
| dma_set | input | 1 | Internal pulse that raises the DMA request |
| dma_req | output | 1 | DMA request flag |

## Verification
Every result is counted from the leading or trailing edge of a strobe that is driven on a falling clock edge. Two synchroniser flops and the state register make busy fall on the third rising edge after the leading edge. Read data follows 1+L edges later, and output-enable drops on the third edge after the trailing edge. The bench samples all outputs on falling edges and counts those samples, so it checks the exact index of the first busy-low sample, the number of busy-low samples and the enable release index. It does not simply wait. Write effects are checked through a later read-back over the host bus. The RAM write pulse and byte enables are observed on the RAM port.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD_RUN,
        ST_RD_HOLD,
        ST_WR_HOLD,
        ST_WR_COMMIT
    } hb_state_e;

    // Decoded strobe activity for both bus styles.
    function automatic logic hb_strobe(input logic moto, input logic hi,
                                       input logic rd_n, input logic wr_n);
        if (moto) return hi ? rd_n : ~rd_n;
        return ~rd_n | ~wr_n;
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int          W       = 6,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
    parameter int DW  = 16,
    parameter int RAW = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [DW/8-1:0] be,
    input  logic [RAW-1:0]  addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata
);
    localparam int NREG = 1 << RAW;
    localparam int NB   = DW / 8;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            for (int b = 0; b < NB; b++)
                if (be[b]) regs[addr][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    assign rdata = regs[addr];
endmodule

// File: rtl/hbus_bridge.sv
module hbus_bridge
    import hbus_pkg::*;
#(
    parameter int AW          = 12,
    parameter int DW          = 16,
    parameter int RAW         = 7,
    parameter int SYNC_STAGES = 2,
    parameter int RAM_CYC     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_moto,
    input  logic            cfg_strobe_hi,
    input  logic            cfg_ram_x2,
    input  logic            h_rd_n,
    input  logic            h_wr_n,
    input  logic [1:0]      h_ram_cs_n,
    input  logic            h_reg_cs_n,
    input  logic            h_reg_cs,
    input  logic            h_ub_n,
    input  logic [AW-1:0]   h_addr,
    input  logic [DW-1:0]   h_din,
    output logic [DW-1:0]   h_dout,
    output logic            h_doe,
    output logic            h_busy_n,
    input  logic            ram_int_busy,
    output logic            ram_host_req,
    output logic            ram_en,
    output logic            ram_we,
    output logic [DW/8-1:0] ram_be,
    output logic [AW-1:0]   ram_addr,
    output logic [DW-1:0]   ram_wdata,
    input  logic [DW-1:0]   ram_rdata,
    input  logic            dma_set,
    output logic            dma_req
);
    localparam int NB       = DW / 8;
    localparam int CW       = $clog2(RAM_CYC + 1);
    localparam int LAT_SLOW = RAM_CYC;
    localparam int LAT_FAST = (RAM_CYC + 1) / 2;
    localparam int CTL_W    = 6;

    // ---------------- synchroniser ----------------
    logic [CTL_W-1:0] ctl_s;
    logic             rd_s, wr_s, regn_s, regp_s;
    logic [1:0]       cs_s;

    hbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(6'b111110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({h_rd_n, h_wr_n, h_ram_cs_n, h_reg_cs_n, h_reg_cs}),
        .q     (ctl_s)
    );
    assign {rd_s, wr_s, cs_s, regn_s, regp_s} = ctl_s;

    // ---------------- decode ----------------
    logic strobe_s, strobe_q, strobe_raw, start, write_s, ram_sel, reg_sel;
    assign strobe_s   = hb_strobe(cfg_moto, cfg_strobe_hi, rd_s, wr_s);
    assign strobe_raw = hb_strobe(cfg_moto, cfg_strobe_hi, h_rd_n, h_wr_n);
    assign start      = strobe_s & ~strobe_q;
    assign write_s    = ~wr_s;
    assign ram_sel    = ~cs_s[0] & ~cs_s[1];
    assign reg_sel    = ~regn_s & regp_s;

    // ---------------- state and datapath ----------------
    hb_state_e         state_q, state_d;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     din_q, dout_q, rf_rdata;
    logic              ub_q, wr_q, reg_q, dma_q, rd_done, rf_we;
    logic [CW-1:0]     cnt_q, lat_last;

    assign lat_last = cfg_ram_x2 ? CW'(LAT_FAST - 1) : CW'(LAT_SLOW - 1);
    assign rd_done  = reg_q || (cnt_q == lat_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            addr_q   <= '0;
            din_q    <= '0;
            dout_q   <= '0;
            ub_q     <= 1'b1;
            wr_q     <= 1'b0;
            reg_q    <= 1'b0;
            cnt_q    <= '0;
            dma_q    <= 1'b0;
        end else begin
            strobe_q <= strobe_s;
            if (strobe_raw) din_q <= h_din;
            if (state_q == ST_IDLE && start) begin
                addr_q <= h_addr;
                ub_q   <= h_ub_n;
                wr_q   <= write_s;
                reg_q  <= ~ram_sel;
            end
            cnt_q <= (state_q == ST_RD_RUN) ? cnt_q + 1'b1 : '0;
            if (state_q == ST_RD_RUN && rd_done)
                dout_q <= reg_q ? rf_rdata : ram_rdata;
            if (dma_set)    dma_q <= 1'b1;
            else if (rf_we) dma_q <= 1'b0;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && ram_sel)      state_d = ST_WAIT;
                else if (start && reg_sel) state_d = write_s ? ST_WR_HOLD : ST_RD_RUN;
            end
            ST_WAIT:      if (!ram_int_busy) state_d = wr_q ? ST_WR_HOLD : ST_RD_RUN;
            ST_RD_RUN:    if (rd_done)       state_d = ST_RD_HOLD;
            ST_RD_HOLD:   if (!strobe_s)     state_d = ST_IDLE;
            ST_WR_HOLD:   if (!strobe_s)     state_d = ST_WR_COMMIT;
            ST_WR_COMMIT:                    state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        h_busy_n     = 1'b1;
        h_doe        = 1'b0;
        ram_host_req = 1'b0;
        ram_en       = 1'b0;
        ram_we       = 1'b0;
        rf_we        = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                h_busy_n     = 1'b0;
                ram_host_req = 1'b1;
            end
            ST_RD_RUN: begin
                h_busy_n     = reg_q;
                ram_host_req = ~reg_q;
                ram_en       = ~reg_q;
            end
            ST_RD_HOLD: h_doe = 1'b1;
            ST_WR_HOLD: ram_host_req = ~reg_q;
            ST_WR_COMMIT: begin
                ram_host_req = ~reg_q;
                ram_en       = ~reg_q;
                ram_we       = ~reg_q;
                rf_we        = reg_q;
            end
            default: ;
        endcase
    end

    assign h_dout    = dout_q;
    assign ram_addr  = addr_q;
    assign ram_wdata = din_q;
    assign ram_be    = {{(NB-1){~ub_q}}, 1'b1};
    assign dma_req   = dma_q;

    hbus_regfile #(.DW(DW), .RAW(RAW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .be    (ram_be),
        .addr  (addr_q[RAW-1:0]),
        .wdata (din_q),
        .rdata (rf_rdata)
    );

    // ---------------- assertions ----------------
    p_busy_excl_doe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !h_busy_n |-> !h_doe);
    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);
    p_low_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_be[0]);
    p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && ram_int_busy) |=> (!ram_en && !h_busy_n && ram_host_req));
    p_dma_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_set |=> dma_req);
    p_dma_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !dma_set) |=> !dma_req);
    p_doe_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (h_doe && !strobe_s) |=> !h_doe);
endmodule

// File: tb/test_hbus_bridge.sv
module test_hbus_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_moto = 1'b0, cfg_strobe_hi = 1'b0, cfg_ram_x2 = 1'b0;
    logic        h_rd_n = 1'b1, h_wr_n = 1'b1, h_reg_cs_n = 1'b1, h_reg_cs = 1'b0, h_ub_n = 1'b0;
    logic [1:0]  h_ram_cs_n = 2'b11;
    logic [11:0] h_addr = '0;
    logic [15:0] h_din = '0, h_dout, ram_wdata, ram_rdata;
    logic        h_doe, h_busy_n, ram_int_busy = 1'b0, ram_host_req, ram_en, ram_we;
    logic [1:0]  ram_be;
    logic [11:0] ram_addr;
    logic        dma_set = 1'b0, dma_req;

    int checks = 0, errors = 0, we_cnt = 0, viol = 0;
    logic [1:0] last_be = '0;
    bit req_seen = 0;
    logic [15:0] mem [0:4095];

    always #10 clk = ~clk;

    hbus_bridge i_hbus_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_moto(cfg_moto), .cfg_strobe_hi(cfg_strobe_hi),
        .cfg_ram_x2(cfg_ram_x2), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_ram_cs_n(h_ram_cs_n),
        .h_reg_cs_n(h_reg_cs_n), .h_reg_cs(h_reg_cs), .h_ub_n(h_ub_n), .h_addr(h_addr),
        .h_din(h_din), .h_dout(h_dout), .h_doe(h_doe), .h_busy_n(h_busy_n),
        .ram_int_busy(ram_int_busy), .ram_host_req(ram_host_req), .ram_en(ram_en),
        .ram_we(ram_we), .ram_be(ram_be), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .dma_set(dma_set), .dma_req(dma_req)
    );

    function automatic logic [15:0] init_val(input logic [11:0] a);
        return {a[7:0], 4'h0, a[11:8]} ^ 16'h5A3C;
    endfunction

    // RAM model
    initial for (int i = 0; i < 4096; i++) mem[i] = init_val(12'(i));
    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) begin
        if (ram_we) begin
            if (ram_be[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
            if (ram_be[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
            we_cnt  <= we_cnt + 1;
            last_be <= ram_be;
        end
        if (ram_en && ram_int_busy) viol <= viol + 1;
        if (ram_host_req && ram_int_busy) req_seen <= 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        h_rd_n     = (cfg_moto && cfg_strobe_hi) ? 1'b0 : 1'b1;
        h_wr_n     = 1'b1;
        h_ram_cs_n = 2'b11;
        h_reg_cs_n = 1'b1;
        h_reg_cs   = 1'b0;
    endtask

    // sel: 0 RAM, 1 registers, 2 nothing, 3 register half-select
    task automatic host_access(input bit wr, input int sel, input logic [11:0] a,
                               input logic [15:0] d, input logic ub,
                               output logic [15:0] rd, output bit got, output int first,
                               output int nbusy, output int doe_off, output bit busy_hi);
        rd = '0; got = 0; first = 0; nbusy = 0; doe_off = 0; busy_hi = 0;
        @(negedge clk);
        h_addr = a; h_din = d; h_ub_n = ub;
        h_ram_cs_n = (sel == 0) ? 2'b00 : 2'b11;
        h_reg_cs_n = (sel == 1 || sel == 3) ? 1'b0 : 1'b1;
        h_reg_cs   = (sel == 1);
        if (cfg_moto) begin
            h_wr_n = wr ? 1'b0 : 1'b1;
            h_rd_n = cfg_strobe_hi ? 1'b1 : 1'b0;
        end else if (wr) h_wr_n = 1'b0;
        else             h_rd_n = 1'b0;
        for (int k = 1; k <= 80; k++) begin
            @(negedge clk);
            if (!h_busy_n) begin
                if (first == 0) first = k;
                nbusy++;
            end
            if (!wr && h_doe && !got) begin rd = h_dout; got = 1; end
            if (!wr && sel < 2 && got) break;
            if ((wr || sel >= 2) && k >= 8 && h_busy_n) break;
        end
        busy_hi = h_busy_n;
        h_rd_n = (cfg_moto && cfg_strobe_hi) ? 1'b0 : 1'b1;
        if (!cfg_moto) h_wr_n = 1'b1;
        if (got) begin
            for (int k = 1; k <= 10; k++) begin
                @(negedge clk);
                if (!h_doe) begin doe_off = k; break; end
            end
        end
        @(negedge clk);
        bus_idle();
        repeat (4) @(negedge clk);
    endtask

    logic [15:0] rd;
    bit got, bhi;
    int first, nb, doff, wc;

    task automatic t_reset();
        @(negedge clk);
        chk(h_busy_n == 1'b1 && h_doe == 1'b0, "R1 busy/doe", {h_busy_n, h_doe}, 2'b10);
        chk(dma_req == 1'b0 && ram_en == 1'b0, "R1 dma/ram_en", {dma_req, ram_en}, 2'b00);
    endtask

    task automatic t_intel_read();
        cfg_moto = 0; cfg_ram_x2 = 0;
        host_access(0, 0, 12'h123, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
        chk(got && rd == init_val(12'h123), "R2 read data", rd, init_val(12'h123));
        chk(first == 3, "R3 busy start", first, 3);
        chk(nb == 3, "R3 busy length slow", nb, 3);
        chk(doff == 3, "R10 doe release", doff, 3);
        cfg_ram_x2 = 1;
        host_access(0, 0, 12'hFFF, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
        chk(rd == init_val(12'hFFF), "R2 read top address", rd, init_val(12'hFFF));
        chk(nb == 2, "R3 busy length fast", nb, 2);
        cfg_ram_x2 = 0;
    endtask

    task automatic t_intel_write_bytes();
        wc = we_cnt;
        host_access(1, 0, 12'h045, 16'hBEEF, 1'b0, rd, got, first, nb, doff, bhi);
        chk(bhi, "R5 busy high before strobe end", bhi, 1);
        chk(we_cnt == wc + 1, "R5 single write pulse", we_cnt - wc, 1);
        chk(last_be == 2'b11, "R6 both lanes", last_be, 2'b11);
        host_access(0, 0, 12'h045, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
        chk(rd == 16'hBEEF, "R5 write read-back", rd, 16'hBEEF);
        host_access(1, 0, 12'h045, 16'h1234, 1'b1, rd, got, first, nb, doff, bhi);
        chk(last_be == 2'b01, "R6 low lane only", last_be, 2'b01);
        host_access(0, 0, 12'h045, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
        chk(rd == 16'hBE34, "R6 upper byte kept", rd, 16'hBE34);
    endtask

    task automatic t_moto();
        @(negedge clk); cfg_moto = 1; cfg_strobe_hi = 0; bus_idle();
        repeat (5) @(negedge clk);
        host_access(1, 0, 12'h200, 16'hCAFE, 1'b0, rd, got, first, nb, doff, bhi);
        host_access(0, 0, 12'h200, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
        chk(rd == 16'hCAFE, "R4 low-active strobe", rd, 16'hCAFE);
        wc = we_cnt;
        @(negedge clk); cfg_strobe_hi = 1; bus_idle();
        repeat (5) @(negedge clk);
        chk(we_cnt == wc && h_busy_n && !h_doe, "R11 polarity switch quiet", {h_busy_n, h_doe}, 2'b10);
        host_access(1, 0, 12'h201, 16'h0F0F, 1'b0, rd, got, first, nb, doff, bhi);
        host_access(0, 0, 12'h201, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
        chk(rd == 16'h0F0F, "R4 high-active strobe", rd, 16'h0F0F);
        host_access(0, 0, 12'h200, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
        chk(rd == 16'hCAFE && first == 3, "R4 high-active read timing", {rd, 16'(first)}, {16'hCAFE, 16'd3});
        @(negedge clk); cfg_moto = 0; cfg_strobe_hi = 0; bus_idle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_int_busy();
        @(negedge clk); ram_int_busy = 1;
        fork
            host_access(0, 0, 12'h123, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
            begin repeat (10) @(negedge clk); ram_int_busy = 0; end
        join
        chk(nb > 6, "R7 busy held while internal busy", nb, 7);
        chk(viol == 0, "R7 no ram_en while internal busy", viol, 0);
        chk(req_seen, "R7 host request raised", req_seen, 1);
        chk(rd == init_val(12'h123), "R7 data after wait", rd, init_val(12'h123));
    endtask

    task automatic t_regs();
        host_access(1, 1, 12'h005, 16'hA5A5, 1'b0, rd, got, first, nb, doff, bhi);
        host_access(0, 1, 12'h005, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
        chk(rd == 16'hA5A5 && nb == 0, "R8 register read, no busy", {rd, 16'(nb)}, {16'hA5A5, 16'd0});
        host_access(1, 1, 12'h005, 16'h1111, 1'b1, rd, got, first, nb, doff, bhi);
        host_access(0, 1, 12'h085, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
        chk(rd == 16'hA511, "R8 alias and R6 byte rule", rd, 16'hA511);
        wc = we_cnt;
        host_access(0, 3, 12'h005, 16'h0, 1'b0, rd, got, first, nb, doff, bhi);
        chk(!got && nb == 0, "R8 half select ignored", {got, 8'(nb)}, 9'd0);
        host_access(1, 2, 12'h046, 16'hDEAD, 1'b0, rd, got, first, nb, doff, bhi);
        chk(we_cnt == wc && nb == 0, "R11 unselected write ignored", we_cnt - wc, 0);
    endtask

    task automatic t_dma();
        @(negedge clk); dma_set = 1;
        @(negedge clk); dma_set = 0;
        chk(dma_req == 1'b1, "R9 dma set", dma_req, 1);
        host_access(1, 1, 12'h010, 16'h0001, 1'b0, rd, got, first, nb, doff, bhi);
        chk(dma_req == 1'b0, "R9 dma cleared by register write", dma_req, 0);
    endtask

    initial begin
        bus_idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (4) @(negedge clk);
        t_intel_read();
        t_intel_write_bytes();
        t_moto();
        t_int_busy();
        t_regs();
        t_dma();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule